// File: doc/BRIEF.md
# Sticky Edge-Event Flag Endpoint

This block collects one-shot events from user logic and holds them until a host, reading much more slowly over a shared register bus, polls for them. Each of the event inputs is sampled on the user clock. A rising edge, meaning low in one sample and high in the next, latches a flag for that bit. The flag stays set until a host read clears it. Because the flags persist, an event lasting a single user-clock cycle is still seen by a host that polls only rarely.

Each detected edge flips a per-bit toggle register in the user clock domain. The toggle is carried into the host clock domain through a synchronizer chain, and a change in the synchronized toggle sets the sticky flag. The endpoint answers a single bus address. A read strobe to that address returns the whole flag vector on the next host cycle and clears it in the same operation. An edge that lands in the clearing cycle is kept for the following poll.

Top module: `trig_out_endpoint`

## Requirements
- R1: Bit i of the flag vector (reported on bit i of `rd_data`) is set when `ev_i[i]` is sampled low on one rising edge of `ev_clk` and high on the next one. A level that stays high raises no further event.
- R2: A pulse that rises and falls between two rising edges of `ev_clk` is never sampled high and produces no event.
- R3: A set flag stays set through any number of host cycles until a poll clears it.
- R4: Several rising edges on one bit between two polls give a single set bit in the next poll, provided each low phase lasts at least four `ev_clk` cycles.
- R5: A poll is `rd_en` high with `rd_addr` equal to `EP_ADDR` at a rising edge of `host_clk`. On the next host cycle `rd_data` holds the flag vector as it stood before the poll, and the flags are cleared.
- R6: In every host cycle that does not follow a poll, `rd_data` is all zero. A read strobe to any other address neither returns data nor clears flags.
- R7: An edge whose crossing lands in the same host cycle as a poll is not lost. Every edge is reported by exactly one poll.
- R8: After reset all flags and previous samples are zero. Inputs that are already high when reset is released raise no event.
- R9: The default configuration has 16 independent bits. An edge on one bit never sets any other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ev_clk | input | 1 | User-domain clock that samples the event inputs |
| ev_rst_n | input | 1 | Active-low asynchronous reset, user domain |
| ev_i | input | N_BITS | Event levels from user logic |
| host_clk | input | 1 | Host bus clock |
| host_rst_n | input | 1 | Active-low asynchronous reset, host domain |
| rd_en | input | 1 | Read strobe on the shared host bus |
| rd_addr | input | ADDR_W | Bus address of the read |
| rd_data | output | N_BITS | Flag vector one cycle after a poll, zero otherwise |

## Verification
The assertions assume that an event bit stays low for at least four user-clock cycles between edges. Under that assumption a toggle cannot flip twice within one synchronizer window. They also assume that both resets are applied together, so that the toggle and its synchronized copy start out equal. The bench drives events only on user-clock falling edges, with low phases of four or more cycles. It asserts both resets at the same time. It places edges at a swept range of host-cycle offsets from a poll, so that the case of a crossing landing exactly on a clear is covered.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int TRIG_W_DEF  = 16;
    localparam int ADDR_W_DEF  = 8;
    localparam int SYNC_N_DEF  = 2;
    localparam int EP_ADDR_DEF = 8'h60;
endpackage

// File: rtl/trig_edge_capture.sv
module trig_edge_capture #(
    parameter int W = trig_pkg::TRIG_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] toggle_o
);
    typedef struct packed {
        logic         armed;
        logic [W-1:0] prev;
        logic [W-1:0] tog;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = 1'b1;
        st_d.prev  = level_i;
        if (st_q.armed) begin
            st_d.tog = st_q.tog ^ (level_i & ~st_q.prev);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign toggle_o = st_q.tog;
endmodule

// File: rtl/trig_toggle_sync.sv
module trig_toggle_sync #(
    parameter int W      = trig_pkg::TRIG_W_DEF,
    parameter int STAGES = trig_pkg::SYNC_N_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] toggle_i,
    output logic [W-1:0] pulse_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             seen;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = toggle_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.seen = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.chain[STAGES-1] ^ st_q.seen;
endmodule

// File: rtl/trig_sticky_bank.sv
module trig_sticky_bank #(
    parameter int                W       = trig_pkg::TRIG_W_DEF,
    parameter int                ADDR_W  = trig_pkg::ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] EP_ADDR = ADDR_W'(trig_pkg::EP_ADDR_DEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      pulse_i,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic [W-1:0]      flags_o
);
    typedef struct packed {
        logic [W-1:0] flags;
        logic [W-1:0] rdata;
    } bank_t;

    bank_t st_d, st_q;
    logic  hit;

    always_comb begin
        hit        = rd_en && (rd_addr == EP_ADDR);
        st_d       = st_q;
        st_d.rdata = hit ? st_q.flags : '0;
        st_d.flags = (hit ? '0 : st_q.flags) | pulse_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;
    assign flags_o = st_q.flags;
endmodule

// File: rtl/trig_out_endpoint.sv
module trig_out_endpoint #(
    parameter int                N_BITS  = trig_pkg::TRIG_W_DEF,
    parameter int                ADDR_W  = trig_pkg::ADDR_W_DEF,
    parameter int                SYNC_N  = trig_pkg::SYNC_N_DEF,
    parameter logic [ADDR_W-1:0] EP_ADDR = ADDR_W'(trig_pkg::EP_ADDR_DEF)
) (
    input  logic              ev_clk,
    input  logic              ev_rst_n,
    input  logic [N_BITS-1:0] ev_i,
    input  logic              host_clk,
    input  logic              host_rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [N_BITS-1:0] rd_data
);
    logic [N_BITS-1:0] tog_w;
    logic [N_BITS-1:0] pulse_w;
    logic [N_BITS-1:0] flags_w;

    trig_edge_capture #(.W(N_BITS)) u_cap (
        .clk      (ev_clk),
        .rst_n    (ev_rst_n),
        .level_i  (ev_i),
        .toggle_o (tog_w)
    );

    trig_toggle_sync #(.W(N_BITS), .STAGES(SYNC_N)) u_sync (
        .clk      (host_clk),
        .rst_n    (host_rst_n),
        .toggle_i (tog_w),
        .pulse_o  (pulse_w)
    );

    trig_sticky_bank #(.W(N_BITS), .ADDR_W(ADDR_W), .EP_ADDR(EP_ADDR)) u_bank (
        .clk     (host_clk),
        .rst_n   (host_rst_n),
        .pulse_i (pulse_w),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .flags_o (flags_w)
    );
endmodule

// File: rtl/trig_out_endpoint_chk.sv
module trig_out_endpoint_chk #(
    parameter int                N_BITS  = 16,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] EP_ADDR = 8'h60
) (
    input logic              ev_clk,
    input logic              ev_rst_n,
    input logic [N_BITS-1:0] ev_i,
    input logic [N_BITS-1:0] tog_w,
    input logic              host_clk,
    input logic              host_rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [N_BITS-1:0] rd_data,
    input logic [N_BITS-1:0] pulse_w,
    input logic [N_BITS-1:0] flags_w
);
    logic hit;
    assign hit = rd_en && (rd_addr == EP_ADDR);

    // R1
    toggle_needs_high_chk: assert property (@(posedge ev_clk) disable iff (!ev_rst_n)
        ((tog_w ^ $past(tog_w)) & ~$past(ev_i)) == '0);

    // R3
    sticky_hold_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        !hit |=> (flags_w & $past(flags_w)) == $past(flags_w));

    // R5
    poll_data_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        hit |=> rd_data == $past(flags_w));

    // R5
    poll_clear_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        hit |=> (flags_w & ~$past(pulse_w)) == '0);

    // R6
    idle_zero_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        !hit |=> rd_data == '0);

    // R7
    pulse_lands_chk: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        (pulse_w != '0) |=> (flags_w & $past(pulse_w)) == $past(pulse_w));
endmodule

bind trig_out_endpoint trig_out_endpoint_chk #(
    .N_BITS (N_BITS),
    .ADDR_W (ADDR_W),
    .EP_ADDR(EP_ADDR)
) u_chk (
    .ev_clk    (ev_clk),
    .ev_rst_n  (ev_rst_n),
    .ev_i      (ev_i),
    .tog_w     (tog_w),
    .host_clk  (host_clk),
    .host_rst_n(host_rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .pulse_w   (pulse_w),
    .flags_w   (flags_w)
);

// File: tb/trig_out_endpoint_tb.sv
`timescale 1ns/100ps
module trig_out_endpoint_tb;
    localparam int          W  = 16;
    localparam logic [7:0]  EP = 8'h60;

    logic          ev_clk = 0, host_clk = 0;
    logic          ev_rst_n = 0, host_rst_n = 0;
    logic [W-1:0]  ev_i = '0;
    logic          rd_en = 0;
    logic [7:0]    rd_addr = '0;
    logic [W-1:0]  rd_data;
    int            n_chk = 0, n_fail = 0;
    bit            done = 0;

    always #2.5 host_clk = ~host_clk;
    always #3.5 ev_clk   = ~ev_clk;

    trig_out_endpoint u_dut (
        .ev_clk(ev_clk), .ev_rst_n(ev_rst_n), .ev_i(ev_i),
        .host_clk(host_clk), .host_rst_n(host_rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic poll(input logic [7:0] addr, output logic [W-1:0] val);
        @(negedge host_clk);
        rd_en = 1; rd_addr = addr;
        @(negedge host_clk);
        rd_en = 0;
        val = rd_data;
    endtask

    task automatic settle();
        repeat (14) @(negedge host_clk);
    endtask

    task automatic pulse_bits(input logic [W-1:0] m);
        @(negedge ev_clk); ev_i = ev_i | m;
        repeat (2) @(negedge ev_clk);
        ev_i = ev_i & ~m;
        repeat (4) @(negedge ev_clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge host_clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] v, a, b, m;
        ev_i = 16'hA5A5;
        repeat (4) @(negedge host_clk);
        check("R8 rd_data in reset", rd_data, '0);
        ev_rst_n = 1; host_rst_n = 1;
        settle();
        poll(EP, v);  check("R8 high at reset", v, '0);
        ev_i = '0; settle();
        poll(EP, v);  check("R8 falling after reset", v, '0);

        // R1 R9 R5: every bit alone, then cleared
        for (int i = 0; i < W; i++) begin
            pulse_bits(16'h1 << i); settle();
            poll(EP, v); check("R9 single bit", v, 16'h1 << i);
            poll(EP, v); check("R5 cleared after poll", v, '0);
        end

        // R1 several patterns
        for (int k = 1; k < 9; k++) begin
            m = 16'((k * 16'h3C5A) ^ (k << 3));
            pulse_bits(m); settle();
            poll(EP, v); check("R1 pattern", v, m);
        end

        // R3 held over a long wait
        pulse_bits(16'h8001);
        repeat (300) @(negedge host_clk);
        poll(EP, v); check("R3 sticky", v, 16'h8001);

        // R4 repeated edges
        pulse_bits(16'h0008); pulse_bits(16'h0008); pulse_bits(16'h0008);
        settle();
        poll(EP, v); check("R4 merged", v, 16'h0008);
        poll(EP, v); check("R4 one event", v, '0);

        // R2 glitch between samples
        @(negedge ev_clk); #1.0 ev_i = 16'h0F00; #1.5 ev_i = '0;
        settle();
        poll(EP, v); check("R2 glitch", v, '0);

        // R1 level held high reports once
        @(negedge ev_clk); ev_i = 16'h0200; settle();
        poll(EP, v); check("R1 rise", v, 16'h0200);
        settle();
        poll(EP, v); check("R1 level no repeat", v, '0);
        ev_i = '0; repeat (6) @(negedge ev_clk);

        // R6 wrong address and idle
        pulse_bits(16'h4040); settle();
        poll(EP ^ 8'h01, v); check("R6 other addr data", v, '0);
        poll(8'h00, v);      check("R6 addr zero data", v, '0);
        @(negedge host_clk); check("R6 idle zero", rd_data, '0);
        poll(EP, v);         check("R6 not cleared", v, 16'h4040);

        // R7 edge against poll at swept offsets
        for (int d = 0; d < 12; d++) begin
            m = 16'h1 << (d % W);
            @(negedge ev_clk); ev_i = m;
            repeat (d) @(negedge host_clk);
            poll(EP, a);
            repeat (2) @(negedge ev_clk);
            ev_i = '0;
            settle();
            poll(EP, b);
            check("R7 reported once", (a | b) & m, m);
            check("R7 not twice", a & b, '0);
            repeat (4) @(negedge ev_clk);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule